// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block watches the control strobes of a fast-page DRAM interface and names each memory cycle as it ends. The inputs are the row strobe, one column strobe per byte lane, write enable and output enable. All of them are active low and are sampled on the system clock. The block decides each cycle type from the order of strobe edges. The OR of the lane column strobes sets the column cycle: the earliest lane falling edge opens it and the last lane rising edge closes it. Write timing is captured separately for each lane.

When a cycle ends, the block raises `op_valid` for one clock. In that clock `op_code` carries the cycle type and `lane_mask` shows the byte lanes that took part. If the lanes of one column cycle used different write modes, `mix_err` is raised in the same clock. When nothing is being reported, the outputs rest at standby. The block can serve as the front end of a memory-side model or as a passive bus monitor. It holds no storage array, and it checks no timing finer than one clock.

Top module: `dram_strobe_classifier`

## Requirements
- R1: While reset is asserted, and after reset is released with all strobes high, `op_valid`, `op_code`, `lane_mask` and `mix_err` are all zero. A reset taken in the middle of a cycle discards that cycle, and no report follows for it.
- R2: `op_code` uses this encoding: 0 standby, 1 read, 2 read with output disabled, 3 early write, 4 delayed write, 5 read-modify-write, 6 row-only refresh, 7 column-before-row refresh. In any clock where `op_valid` is 0, `op_code` is 0, `lane_mask` is 0 and `mix_err` is 0.
- R3: The row strobe falls while every lane column strobe is high, then rises with no column cycle in between. This is reported as code 6 with every lane bit set. The pulse appears on the second rising clock edge after the row strobe rise is presented to the inputs.
- R4: The row strobe falls while at least one lane column strobe is already low (for example, upper lane high and lower lane low). This is reported as code 7 with every lane bit set, when the row strobe rises.
- R5: A column cycle is reported when the last low lane column strobe returns high. Bit i of `lane_mask` is set when lane i's column strobe fell during that column cycle. Bit 0 is the lower lane and bit 1 is the upper lane.
- R6: When write enable is already low at a lane's column strobe falling edge, that lane is an early write, and the cycle reports code 3.
- R7: When write enable falls after the column cycle opened and output enable was not low before that fall, the cycle is a delayed write, and it reports code 4.
- R8: When output enable was low while write enable was still high, and write enable then falls in the same column cycle, the cycle is a read-modify-write, and it reports code 5.
- R9: A column cycle with write enable high throughout reports code 1 if output enable was low at some point during it. Otherwise it reports code 2.
- R10: If at least one active lane of a column cycle is an early write and at least one is not, the cycle reports code 3 with `mix_err` high in the same clock.
- R11: Each column cycle inside one row strobe low period is reported separately (fast page). A row period that had a column cycle produces no refresh report when the row strobe rises.
- R12: A column cycle that is still open when the row strobe rises is reported when its column strobes rise. A row strobe fall during that held column cycle starts a column-before-row refresh, reported at the next row strobe rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | LANES | Column strobe per byte lane, active low; bit 0 is the lower lane |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| op_valid | output | 1 | One-clock pulse when a cycle is reported |
| op_code | output | 3 | Cycle type, encoded as in R2 |
| lane_mask | output | LANES | Byte lanes that took part in the reported cycle |
| mix_err | output | 1 | Write modes differed across lanes in the reported cycle |

## Verification
The assertions take for granted that every strobe level stays put for at least one clock, so that each edge is seen in its own sample. They also take for granted that a column cycle close and a row strobe rise never land in the same sample, because the column report wins and that refresh report would be lost. The stimulus holds each input pattern for several clocks and changes the strobes one step at a time. In the hidden refresh sequence it moves the row strobe and the column strobes in separate steps.

// File: rtl/dcls_pkg.sv
`timescale 1ns/1ps
package dcls_pkg;

  typedef enum logic [2:0] {
    OP_STANDBY    = 3'd0,
    OP_READ       = 3'd1,
    OP_READ_HIZ   = 3'd2,
    OP_WR_EARLY   = 3'd3,
    OP_WR_DELAYED = 3'd4,
    OP_RMW        = 3'd5,
    OP_REF_ROW    = 3'd6,
    OP_REF_CBR    = 3'd7
  } op_e;

  // Column cycle type from the captured per-cycle flags.
  function automatic op_e col_kind(input logic any_early,
                                   input logic late_we,
                                   input logic oe_seen);
    if (any_early)    return OP_WR_EARLY;
    else if (late_we) return oe_seen ? OP_RMW : OP_WR_DELAYED;
    else              return oe_seen ? OP_READ : OP_READ_HIZ;
  endfunction

endpackage

// File: rtl/dcls_sampler.sv
`timescale 1ns/1ps
module dcls_sampler #(
  parameter int unsigned    W   = 5,
  parameter logic [W-1:0]   RST = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur  <= RST;
      prev <= RST;
    end else begin
      cur  <= din;
      prev <= cur;
    end
  end

endmodule

// File: rtl/dcls_lanes.sv
`timescale 1ns/1ps
module dcls_lanes #(
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] cas_cur,
  input  logic [LANES-1:0] cas_prev,
  input  logic             we_cur,
  input  logic             col_start,
  input  logic             col_active,
  input  logic             idle_clear,
  output logic [LANES-1:0] lane_hit,
  output logic [LANES-1:0] lane_early,
  output logic             lanes_mixed
);

  logic [LANES-1:0] lane_fall;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_fall[i] = ~cas_cur[i] & cas_prev[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_hit[i]   <= 1'b0;
        lane_early[i] <= 1'b0;
      end else if (col_start) begin
        lane_hit[i]   <= lane_fall[i];
        lane_early[i] <= lane_fall[i] & ~we_cur;
      end else if (col_active && lane_fall[i]) begin
        lane_hit[i]   <= 1'b1;
        lane_early[i] <= ~we_cur;
      end else if (idle_clear) begin
        lane_hit[i]   <= 1'b0;
        lane_early[i] <= 1'b0;
      end
    end
  end

  assign lanes_mixed = (|(lane_hit & lane_early)) & (|(lane_hit & ~lane_early));

  // R6: a lane is only marked early once its strobe has joined the cycle
  assert_early_in_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_early & ~lane_hit) == '0);

endmodule

// File: rtl/dcls_column.sv
`timescale 1ns/1ps
module dcls_column (
  input  logic clk,
  input  logic rst_n,
  input  logic cas_any_cur,
  input  logic cas_any_prev,
  input  logic ras_cur,
  input  logic row_open,
  input  logic we_cur,
  input  logic we_prev,
  input  logic oe_cur,
  output logic col_start,
  output logic col_end,
  output logic col_active,
  output logic late_we,
  output logic oe_seen
);

  logic we_fall;

  assign we_fall   = ~we_cur & we_prev;
  assign col_start = cas_any_cur & ~cas_any_prev & ~ras_cur & row_open & ~col_active;
  assign col_end   = col_active & ~cas_any_cur & cas_any_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_active <= 1'b0;
      late_we    <= 1'b0;
      oe_seen    <= 1'b0;
    end else begin
      if (col_start)    col_active <= 1'b1;
      else if (col_end) col_active <= 1'b0;

      if (col_start)                 late_we <= 1'b0;
      else if (col_active && we_fall) late_we <= 1'b1;

      if (col_start)
        oe_seen <= ~oe_cur & we_cur;
      else if (col_active && !late_we && we_cur && !oe_cur)
        oe_seen <= 1'b1;
    end
  end

  // R5: an opened column cycle stays open until its close is seen
  assert_start_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
    col_start |=> col_active);

  assert_end_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    col_end |=> !col_active);

endmodule

// File: rtl/dram_strobe_classifier.sv
`timescale 1ns/1ps
module dram_strobe_classifier #(
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic [LANES-1:0] cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  output logic             op_valid,
  output logic [2:0]       op_code,
  output logic [LANES-1:0] lane_mask,
  output logic             mix_err
);
  import dcls_pkg::*;

  localparam int unsigned SW = LANES + 3;

  logic [SW-1:0]    smp_cur, smp_prev;
  logic             ras_cur, ras_prev, we_cur, we_prev, oe_cur, oe_prev;
  logic [LANES-1:0] cas_cur, cas_prev;
  logic             cas_any_cur, cas_any_prev;
  logic             ras_fall, ras_rise;
  logic             row_open, cbr_pend, col_seen;
  logic             col_start, col_end, col_active, late_we, oe_seen;
  logic [LANES-1:0] lane_hit, lane_early;
  logic             lanes_mixed;
  logic             ev_valid, ev_err;
  op_e              ev_op;
  logic [LANES-1:0] ev_mask;

  dcls_sampler #(.W(SW), .RST({SW{1'b1}})) u_smp (
    .clk(clk), .rst_n(rst_n),
    .din({ras_n, cas_n, we_n, oe_n}),
    .cur(smp_cur), .prev(smp_prev)
  );

  assign {ras_cur, cas_cur, we_cur, oe_cur}     = smp_cur;
  assign {ras_prev, cas_prev, we_prev, oe_prev} = smp_prev;

  assign cas_any_cur  = ~&cas_cur;
  assign cas_any_prev = ~&cas_prev;
  assign ras_fall     = ~ras_cur & ras_prev;
  assign ras_rise     = ras_cur & ~ras_prev;

  dcls_column u_col (
    .clk(clk), .rst_n(rst_n),
    .cas_any_cur(cas_any_cur), .cas_any_prev(cas_any_prev),
    .ras_cur(ras_cur), .row_open(row_open),
    .we_cur(we_cur), .we_prev(we_prev), .oe_cur(oe_cur),
    .col_start(col_start), .col_end(col_end), .col_active(col_active),
    .late_we(late_we), .oe_seen(oe_seen)
  );

  dcls_lanes #(.LANES(LANES)) u_lanes (
    .clk(clk), .rst_n(rst_n),
    .cas_cur(cas_cur), .cas_prev(cas_prev), .we_cur(we_cur),
    .col_start(col_start), .col_active(col_active),
    .idle_clear(ras_cur & ~col_active),
    .lane_hit(lane_hit), .lane_early(lane_early), .lanes_mixed(lanes_mixed)
  );

  // Row-level state: which kind of row period is in progress
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_open <= 1'b0;
      cbr_pend <= 1'b0;
      col_seen <= 1'b0;
    end else begin
      if (ras_fall) begin
        row_open <= ~cas_any_cur;
        cbr_pend <= cas_any_cur;
        if (!cas_any_cur) col_seen <= 1'b0;
      end else if (ras_rise) begin
        row_open <= 1'b0;
        cbr_pend <= 1'b0;
      end
      if (col_start) col_seen <= 1'b1;
    end
  end

  always_comb begin
    ev_valid = 1'b0;
    ev_op    = OP_STANDBY;
    ev_mask  = '0;
    ev_err   = 1'b0;
    if (col_end) begin
      ev_valid = 1'b1;
      ev_op    = col_kind(|(lane_hit & lane_early), late_we, oe_seen);
      ev_mask  = lane_hit;
      ev_err   = lanes_mixed;
    end else if (ras_rise && cbr_pend) begin
      ev_valid = 1'b1;
      ev_op    = OP_REF_CBR;
      ev_mask  = '1;
    end else if (ras_rise && row_open && !col_seen) begin
      ev_valid = 1'b1;
      ev_op    = OP_REF_ROW;
      ev_mask  = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_valid  <= 1'b0;
      op_code   <= OP_STANDBY;
      lane_mask <= '0;
      mix_err   <= 1'b0;
    end else begin
      op_valid  <= ev_valid;
      op_code   <= ev_op;
      lane_mask <= ev_mask;
      mix_err   <= ev_err;
    end
  end

  // R2: outputs rest at standby between reports
  assert_quiet_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (op_code == 3'd0 && lane_mask == '0 && !mix_err));

  // R3: row-only refresh covers all lanes and follows a sampled row rise
  assert_row_ref_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd6) |-> (lane_mask == '1 && $past(ras_cur)));

  // R4: column-before-row refresh covers all lanes
  assert_cbr_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd7) |-> (lane_mask == '1 && $past(ras_cur)));

  // R5: a column report names at least one lane
  assert_col_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code != 3'd6 && op_code != 3'd7) |-> (lane_mask != '0));

  // R10: a lane mix always rides on an early-write report
  assert_mix_early_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mix_err |-> (op_valid && op_code == 3'd3));

endmodule

// File: tb/dram_strobe_classifier_bench.sv
`timescale 1ns/1ps
module dram_strobe_classifier_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ras_n = 1'b1;
  logic [1:0] cas_n = 2'b11;
  logic       we_n = 1'b1;
  logic       oe_n = 1'b1;
  logic       op_valid;
  logic [2:0] op_code;
  logic [1:0] lane_mask;
  logic       mix_err;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  dram_strobe_classifier #(.LANES(2)) u_dram_strobe_classifier (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .oe_n(oe_n), .op_valid(op_valid), .op_code(op_code),
    .lane_mask(lane_mask), .mix_err(mix_err)
  );

  // vector: [19:16] req, [15:11] {ras,cas_u,cas_l,we,oe}, [10:8] pulses, [7:5] op, [4:3] mask, [2] err
  function automatic logic [19:0] v(input logic [3:0] req, input logic [4:0] pins,
                                    input logic pulse, input logic [2:0] op,
                                    input logic [1:0] msk, input logic err);
    return {req, pins, 2'b00, pulse, op, msk, err, 2'b00};
  endfunction

  localparam int NV = 58;
  localparam logic [19:0] VEC [NV] = '{
    v(2, 5'b11111, 0, 0, 2'b00, 0),   // R2 standby
    v(3, 5'b01111, 0, 0, 2'b00, 0),   // R3 row-only refresh
    v(3, 5'b11111, 1, 6, 2'b11, 0),
    v(9, 5'b01111, 0, 0, 2'b00, 0),   // R9 word read
    v(9, 5'b00010, 0, 0, 2'b00, 0),
    v(9, 5'b01111, 1, 1, 2'b11, 0),
    v(11, 5'b11111, 0, 0, 2'b00, 0),  // R11 no refresh after column
    v(5, 5'b01111, 0, 0, 2'b00, 0),   // R5 lower lane read
    v(5, 5'b01010, 0, 0, 2'b00, 0),
    v(5, 5'b01111, 1, 1, 2'b01, 0),
    v(5, 5'b11111, 0, 0, 2'b00, 0),
    v(9, 5'b01111, 0, 0, 2'b00, 0),   // R9 upper read, output disabled
    v(9, 5'b00111, 0, 0, 2'b00, 0),
    v(9, 5'b01111, 1, 2, 2'b10, 0),
    v(9, 5'b11111, 0, 0, 2'b00, 0),
    v(6, 5'b01111, 0, 0, 2'b00, 0),   // R6 early write
    v(6, 5'b01101, 0, 0, 2'b00, 0),
    v(6, 5'b00001, 0, 0, 2'b00, 0),
    v(6, 5'b01111, 1, 3, 2'b11, 0),
    v(6, 5'b11111, 0, 0, 2'b00, 0),
    v(7, 5'b01111, 0, 0, 2'b00, 0),   // R7 delayed write
    v(7, 5'b00011, 0, 0, 2'b00, 0),
    v(7, 5'b00001, 0, 0, 2'b00, 0),
    v(7, 5'b01111, 1, 4, 2'b11, 0),
    v(7, 5'b11111, 0, 0, 2'b00, 0),
    v(8, 5'b01111, 0, 0, 2'b00, 0),   // R8 read-modify-write
    v(8, 5'b00010, 0, 0, 2'b00, 0),
    v(8, 5'b00011, 0, 0, 2'b00, 0),
    v(8, 5'b00001, 0, 0, 2'b00, 0),
    v(8, 5'b01111, 1, 5, 2'b11, 0),
    v(8, 5'b11111, 0, 0, 2'b00, 0),
    v(10, 5'b01111, 0, 0, 2'b00, 0),  // R10 lower early, upper delayed
    v(10, 5'b01001, 0, 0, 2'b00, 0),
    v(10, 5'b01011, 0, 0, 2'b00, 0),
    v(10, 5'b00011, 0, 0, 2'b00, 0),
    v(10, 5'b00001, 0, 0, 2'b00, 0),
    v(10, 5'b01111, 1, 3, 2'b11, 1),
    v(10, 5'b11111, 0, 0, 2'b00, 0),
    v(11, 5'b01111, 0, 0, 2'b00, 0),  // R11 fast page: read then write
    v(11, 5'b00010, 0, 0, 2'b00, 0),
    v(11, 5'b01111, 1, 1, 2'b11, 0),
    v(11, 5'b01101, 0, 0, 2'b00, 0),
    v(11, 5'b00001, 0, 0, 2'b00, 0),
    v(11, 5'b01111, 1, 3, 2'b11, 0),
    v(11, 5'b11111, 0, 0, 2'b00, 0),
    v(4, 5'b11011, 0, 0, 2'b00, 0),   // R4 lower low before row fall
    v(4, 5'b01011, 0, 0, 2'b00, 0),
    v(4, 5'b01111, 0, 0, 2'b00, 0),
    v(4, 5'b11111, 1, 7, 2'b11, 0),
    v(12, 5'b01111, 0, 0, 2'b00, 0),  // R12 hidden refresh
    v(12, 5'b00010, 0, 0, 2'b00, 0),
    v(12, 5'b10010, 0, 0, 2'b00, 0),
    v(12, 5'b00010, 0, 0, 2'b00, 0),
    v(12, 5'b10010, 1, 7, 2'b11, 0),
    v(12, 5'b11111, 1, 1, 2'b11, 0),
    v(3, 5'b01111, 0, 0, 2'b00, 0),   // R3 second row-only refresh
    v(3, 5'b11111, 1, 6, 2'b11, 0),
    v(2, 5'b11111, 0, 0, 2'b00, 0)    // R2 standby again
  };

  int         cap_cnt;
  logic [5:0] cap_val;

  always @(posedge clk) begin
    #1;
    if (op_valid) begin
      cap_cnt = cap_cnt + 1;
      cap_val = {op_code, lane_mask, mix_err};
    end
  end

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got cnt/op/mask/err=%h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [4:0] p);
    {ras_n, cas_n, we_n, oe_n} = p;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cap_cnt = 0;
    cap_val = '0;
    // R1: outputs at rest during reset
    repeat (3) @(posedge clk);
    #2 check("R1", {3'd0, op_valid, op_code, lane_mask, mix_err}, 9'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][15:11]);
      cap_cnt = 0;
      cap_val = '0;
      repeat (3) @(posedge clk);
      #2;
      if (cap_cnt == 0) cap_val = {op_code, lane_mask, mix_err};
      check($sformatf("R%0d step %0d", VEC[i][19:16], i),
            {cap_cnt[2:0], cap_val}, VEC[i][10:2]);
    end

    // R3: exact latency of the row-only refresh pulse
    @(negedge clk) drive(5'b01111);
    repeat (2) @(negedge clk);
    drive(5'b11111);
    @(posedge clk); #1;
    check("R3 latency edge1", {5'd0, op_valid, 3'd0}, 9'd0);
    @(posedge clk); #1;
    check("R3 latency edge2", {5'd0, op_valid, op_code}, {5'd0, 1'b1, 3'd6});
    repeat (2) @(negedge clk);

    // R1: reset in the middle of a read discards it
    drive(5'b01111);
    repeat (2) @(negedge clk);
    drive(5'b00010);
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    drive(5'b11111);
    @(negedge clk) rst_n = 1'b1;
    cap_cnt = 0;
    cap_val = '0;
    repeat (4) @(posedge clk);
    #2;
    check("R1 mid-cycle reset", {cap_cnt[2:0], op_code, lane_mask, mix_err}, 9'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule